// File: doc/BRIEF.md
# Hot-Plug Slot Power-Down Sequencer

This block drives the control pins of one hot-pluggable expansion slot: the low-true bus-connect switch, the low-true slot reset, the low-true clock gate, the high-true power switch and two indicator lamps (green, amber). Once the slot is live, a one-cycle power-down command starts the disconnect. The block first asks the bus arbiter to hold the bus and waits for the grant, so that switching the bus signals cannot disturb other masters. It then steps through a fixed order: isolate the bus, assert reset, stop the clock, and remove power. Each step waits a parameter-defined number of clock cycles.

The three spacings are given as clock counts. An elaboration check ties them to the intended clock frequency. The bus-isolate-to-reset spacing must round up to within one clock of 330 ns. The reset-to-clock-stop spacing must lie between 5.468 us and 14.445 us. The clock-stop-to-power-off spacing must lie between 5.438 us and 14.415 us. A one-cycle strobe from the power-up logic elsewhere hands over a slot that is already live. The primary reset is asynchronous and puts every pin into its safe state at once.

Top module: `slotpd_seq`

## Requirements
- R1: While `rst_n` is low and after it is released: slot_rst_n_o=0, bus_en_n_o=1, clk_en_n_o=1, pwr_en_o=0, both lamps off, hold_req_o=0 and done_o=0.
- R2: A `live_set_i` strobe seen at a clock edge while the slot is off makes the slot live from that edge: bus_en_n_o=0, slot_rst_n_o=1, clk_en_n_o=0, pwr_en_o=1, led_green_o=1, led_amber_o=0.
- R3: A `pd_cmd_i` strobe seen at an edge while the slot is live raises hold_req_o and led_amber_o from that edge. bus_en_n_o stays 0 until the grant is seen.
- R4: bus_en_n_o goes to 1 at the first edge at which hold_req_o and hold_gnt_i are both high. A grant held high before the command therefore isolates the bus one edge after hold_req_o rises.
- R5: slot_rst_n_o falls exactly GAP_BUS clock cycles after bus_en_n_o rises.
- R6: clk_en_n_o rises exactly GAP_RST cycles after slot_rst_n_o falls.
- R7: pwr_en_o falls exactly GAP_CLK cycles after clk_en_n_o rises. In that same cycle done_o is high for exactly one cycle and both lamps go off.
- R8: With HOLD_THROUGH_CLK=0, hold_req_o drops at the edge where slot reset asserts. With 1, it stays high until the clock stops.
- R9: `pd_cmd_i` and `live_set_i` have no effect while a disconnect is in progress. `pd_cmd_i` has no effect while the slot is off.
- R10: Pulling `rst_n` low in any phase drives the R1 safe pin values at once, without waiting for a clock edge.
- R11: The pins never show a later step without the earlier ones. Power off implies clock stopped, clock stopped implies reset asserted, and reset asserted implies bus isolated.
- R12: led_green_o is high exactly while pwr_en_o is high. led_amber_o is high from the hold request until power is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Primary reset, asynchronous, low-true |
| live_set_i | input | 1 | Strobe: slot handed over in live state |
| pd_cmd_i | input | 1 | Strobe: start the power-down |
| hold_gnt_i | input | 1 | Bus hold granted by the arbiter |
| hold_req_o | output | 1 | Bus hold request to the arbiter |
| bus_en_n_o | output | 1 | Bus-connect switch enable, low-true |
| slot_rst_n_o | output | 1 | Slot reset, low-true |
| clk_en_n_o | output | 1 | Slot clock gate enable, low-true |
| pwr_en_o | output | 1 | Slot power enable, high-true |
| led_green_o | output | 1 | Power indicator lamp |
| led_amber_o | output | 1 | Attention lamp, lit during disconnect |
| done_o | output | 1 | One-cycle pulse when power is removed |

## Verification
Every pin is decoded from a single phase register, so a strobe or grant seen at edge N shows on the pins one edge later. The bench drives inputs on falling edges and reads pins on the next falling edge. Each of the three spacings is measured by counting falling edges from the first one that shows the earlier step to the first one that shows the next step. That count must equal the spacing parameter exactly, even while ignored strobes are injected. The asynchronous reset is checked a few nanoseconds after `rst_n` falls, with no clock edge in between.

// File: rtl/slotpd_pkg.sv
package slotpd_pkg;

   typedef enum logic [2:0] {
      PH_OFF    = 3'd0,
      PH_LIVE   = 3'd1,
      PH_HOLD   = 3'd2,
      PH_BUSOFF = 3'd3,
      PH_RSTON  = 3'd4,
      PH_CLKOFF = 3'd5
   } phase_t;

   typedef struct packed {
      logic hold_req;
      logic bus_en_n;
      logic slot_rst_n;
      logic clk_en_n;
      logic pwr_en;
      logic led_green;
      logic led_amber;
   } slot_pins_t;

endpackage

// File: rtl/slotpd_gap_timer.sv
module slotpd_gap_timer #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/slotpd_ctrl.sv
module slotpd_ctrl
   import slotpd_pkg::*;
#(
   parameter int CNT_W   = 9,
   parameter int GAP_BUS = 11,
   parameter int GAP_RST = 300,
   parameter int GAP_CLK = 300
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             live_set_i,
   input  logic             pd_cmd_i,
   input  logic             hold_gnt_i,
   input  logic             tmr_expired,
   output phase_t           phase,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             done
);

   localparam logic [CNT_W-1:0] LD_BUS = CNT_W'(GAP_BUS - 1);
   localparam logic [CNT_W-1:0] LD_RST = CNT_W'(GAP_RST - 1);
   localparam logic [CNT_W-1:0] LD_CLK = CNT_W'(GAP_CLK - 1);

   phase_t phase_q, phase_d;
   logic   done_q, done_d;

   always_comb begin
      phase_d  = phase_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      done_d   = 1'b0;
      case (phase_q)
         PH_OFF: begin
            if (live_set_i) phase_d = PH_LIVE;
         end
         PH_LIVE: begin
            if (pd_cmd_i) phase_d = PH_HOLD;
         end
         PH_HOLD: begin
            if (hold_gnt_i) begin
               phase_d  = PH_BUSOFF;
               tmr_load = 1'b1;
               tmr_val  = LD_BUS;
            end
         end
         PH_BUSOFF: begin
            if (tmr_expired) begin
               phase_d  = PH_RSTON;
               tmr_load = 1'b1;
               tmr_val  = LD_RST;
            end
         end
         PH_RSTON: begin
            if (tmr_expired) begin
               phase_d  = PH_CLKOFF;
               tmr_load = 1'b1;
               tmr_val  = LD_CLK;
            end
         end
         PH_CLKOFF: begin
            if (tmr_expired) begin
               phase_d = PH_OFF;
               done_d  = 1'b1;
            end
         end
         default: phase_d = PH_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_OFF;
         done_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done_q  <= done_d;
      end
   end

   assign phase = phase_q;
   assign done  = done_q;

   AST_LIVE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_LIVE && $past(phase_q) != PH_LIVE)
         |-> ($past(phase_q) == PH_OFF && $past(live_set_i))); // R2

   AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_HOLD && $past(phase_q) != PH_HOLD)
         |-> ($past(phase_q) == PH_LIVE && $past(pd_cmd_i))); // R9

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R7

endmodule

// File: rtl/slotpd_drive.sv
module slotpd_drive
   import slotpd_pkg::*;
#(
   parameter bit HOLD_THROUGH_CLK = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  phase_t     phase,
   output slot_pins_t pins
);

   logic hold_in_rst;

   generate
      if (HOLD_THROUGH_CLK) begin : g_hold_long
         assign hold_in_rst = 1'b1;
      end else begin : g_hold_short
         assign hold_in_rst = 1'b0;
      end
   endgenerate

   always_comb begin
      case (phase)
         PH_LIVE:   pins = '{hold_req: 1'b0, bus_en_n: 1'b0, slot_rst_n: 1'b1,
                             clk_en_n: 1'b0, pwr_en: 1'b1, led_green: 1'b1, led_amber: 1'b0};
         PH_HOLD:   pins = '{hold_req: 1'b1, bus_en_n: 1'b0, slot_rst_n: 1'b1,
                             clk_en_n: 1'b0, pwr_en: 1'b1, led_green: 1'b1, led_amber: 1'b1};
         PH_BUSOFF: pins = '{hold_req: 1'b1, bus_en_n: 1'b1, slot_rst_n: 1'b1,
                             clk_en_n: 1'b0, pwr_en: 1'b1, led_green: 1'b1, led_amber: 1'b1};
         PH_RSTON:  pins = '{hold_req: hold_in_rst, bus_en_n: 1'b1, slot_rst_n: 1'b0,
                             clk_en_n: 1'b0, pwr_en: 1'b1, led_green: 1'b1, led_amber: 1'b1};
         PH_CLKOFF: pins = '{hold_req: 1'b0, bus_en_n: 1'b1, slot_rst_n: 1'b0,
                             clk_en_n: 1'b1, pwr_en: 1'b1, led_green: 1'b1, led_amber: 1'b1};
         default:   pins = '{hold_req: 1'b0, bus_en_n: 1'b1, slot_rst_n: 1'b0,
                             clk_en_n: 1'b1, pwr_en: 1'b0, led_green: 1'b0, led_amber: 1'b0};
      endcase
   end

   AST_RESET_SAFE: assert property (@(posedge clk)
      !rst_n |-> (!pins.pwr_en && pins.clk_en_n && !pins.slot_rst_n && pins.bus_en_n
                  && !pins.led_green && !pins.led_amber && !pins.hold_req)); // R1

   AST_RST_AFTER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      !pins.slot_rst_n |-> pins.bus_en_n); // R11

   AST_CLK_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
      pins.clk_en_n |-> !pins.slot_rst_n); // R11

   AST_PWR_AFTER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      !pins.pwr_en |-> pins.clk_en_n); // R11

   AST_BUS_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pins.bus_en_n) |-> $past(pins.hold_req)); // R4

endmodule

// File: rtl/slotpd_seq.sv
module slotpd_seq
   import slotpd_pkg::*;
#(
   parameter int CLK_MHZ          = 33,
   parameter int GAP_BUS          = 11,
   parameter int GAP_RST          = 300,
   parameter int GAP_CLK          = 300,
   parameter bit HOLD_THROUGH_CLK = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic live_set_i,
   input  logic pd_cmd_i,
   input  logic hold_gnt_i,
   output logic hold_req_o,
   output logic bus_en_n_o,
   output logic slot_rst_n_o,
   output logic clk_en_n_o,
   output logic pwr_en_o,
   output logic led_green_o,
   output logic led_amber_o,
   output logic done_o
);

   localparam int GAP_MAX_A = (GAP_BUS > GAP_RST) ? GAP_BUS : GAP_RST;
   localparam int GAP_MAX   = (GAP_MAX_A > GAP_CLK) ? GAP_MAX_A : GAP_CLK;
   localparam int CNT_W     = $clog2(GAP_MAX + 1);
   localparam int CHK_W     = CNT_W + 1;

   generate
      if (CLK_MHZ < 1) begin : g_bad_clk
         $error("slotpd_seq: CLK_MHZ must be positive");
      end
      if (GAP_BUS < 1 || GAP_RST < 1 || GAP_CLK < 1) begin : g_bad_gap
         $error("slotpd_seq: every gap needs at least one cycle");
      end
      if (GAP_BUS * 1000 < 330 * CLK_MHZ || GAP_BUS * 1000 >= 330 * CLK_MHZ + 1000) begin : g_bad_bus
         $error("slotpd_seq: GAP_BUS must be 330 ns rounded up to a whole clock");
      end
      if (GAP_RST * 1000 < 5468 * CLK_MHZ || GAP_RST * 1000 > 14445 * CLK_MHZ) begin : g_bad_rst
         $error("slotpd_seq: GAP_RST outside 5.468 us .. 14.445 us");
      end
      if (GAP_CLK * 1000 < 5438 * CLK_MHZ || GAP_CLK * 1000 > 14415 * CLK_MHZ) begin : g_bad_clkgap
         $error("slotpd_seq: GAP_CLK outside 5.438 us .. 14.415 us");
      end
   endgenerate

   phase_t           phase;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_expired;
   slot_pins_t       pins;

   slotpd_ctrl #(
      .CNT_W   (CNT_W),
      .GAP_BUS (GAP_BUS),
      .GAP_RST (GAP_RST),
      .GAP_CLK (GAP_CLK)
   ) i_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .live_set_i  (live_set_i),
      .pd_cmd_i    (pd_cmd_i),
      .hold_gnt_i  (hold_gnt_i),
      .tmr_expired (tmr_expired),
      .phase       (phase),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .done        (done_o)
   );

   slotpd_gap_timer #(
      .CNT_W (CNT_W)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   slotpd_drive #(
      .HOLD_THROUGH_CLK (HOLD_THROUGH_CLK)
   ) i_drive (
      .clk   (clk),
      .rst_n (rst_n),
      .phase (phase),
      .pins  (pins)
   );

   assign hold_req_o   = pins.hold_req;
   assign bus_en_n_o   = pins.bus_en_n;
   assign slot_rst_n_o = pins.slot_rst_n;
   assign clk_en_n_o   = pins.clk_en_n;
   assign pwr_en_o     = pins.pwr_en;
   assign led_green_o  = pins.led_green;
   assign led_amber_o  = pins.led_amber;

   // Spacing checker: cycles since the last change of any sequenced pin.
   logic [3:0]       chk_prev;
   logic [CHK_W-1:0] chk_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_prev <= 4'b1011;
         chk_cnt  <= '0;
      end else begin
         chk_prev <= {bus_en_n_o, slot_rst_n_o, clk_en_n_o, pwr_en_o};
         if (chk_prev != {bus_en_n_o, slot_rst_n_o, clk_en_n_o, pwr_en_o}) begin
            chk_cnt <= CHK_W'(1);
         end else if (chk_cnt != '1) begin
            chk_cnt <= chk_cnt + 1'b1;
         end
      end
   end

   AST_GNT_BEFORE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_en_n_o) |-> $past(hold_gnt_i)); // R4

   AST_BUS_TO_RST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(slot_rst_n_o) |-> (chk_cnt == CHK_W'(GAP_BUS))); // R5

   AST_RST_TO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_en_n_o) |-> (chk_cnt == CHK_W'(GAP_RST))); // R6

   AST_CLK_TO_PWR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_en_o) |-> (chk_cnt == CHK_W'(GAP_CLK) && done_o)); // R7

endmodule

// File: tb/test_slotpd_seq.sv
module test_slotpd_seq;

   localparam int GB  = 11;
   localparam int GR  = 300;
   localparam int GC  = 300;
   localparam bit HTC = 1'b0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic live_set = 1'b0;
   logic pd_cmd = 1'b0;
   logic hold_gnt = 1'b0;
   logic hold_req, bus_en_n, slot_rst_n, clk_en_n, pwr_en, led_green, led_amber, done;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   slotpd_seq #(
      .CLK_MHZ (33), .GAP_BUS (GB), .GAP_RST (GR), .GAP_CLK (GC), .HOLD_THROUGH_CLK (HTC)
   ) i_slotpd_seq (
      .clk (clk), .rst_n (rst_n), .live_set_i (live_set), .pd_cmd_i (pd_cmd),
      .hold_gnt_i (hold_gnt), .hold_req_o (hold_req), .bus_en_n_o (bus_en_n),
      .slot_rst_n_o (slot_rst_n), .clk_en_n_o (clk_en_n), .pwr_en_o (pwr_en),
      .led_green_o (led_green), .led_amber_o (led_amber), .done_o (done)
   );

   wire [6:0] pins = {hold_req, bus_en_n, slot_rst_n, clk_en_n, pwr_en, led_green, led_amber};

   // Phase codes: 0 off, 1 live, 2 hold wait, 3 bus isolated, 4 reset on, 5 clock off
   function automatic logic [6:0] exp_pins(input int ph);
      case (ph)
         1: return 7'b0_0_1_0_1_1_0;
         2: return 7'b1_0_1_0_1_1_1;
         3: return 7'b1_1_1_0_1_1_1;
         4: return {HTC, 6'b1_0_0_1_1_1};
         5: return 7'b0_1_0_1_1_1_1;
         default: return 7'b0_1_0_1_0_0_0;
      endcase
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk_vec(input string req, input logic [6:0] act, input logic [6:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s pins actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic chk_int(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic pick(input int sel);
      case (sel)
         0: return slot_rst_n;
         1: return clk_en_n;
         default: return pwr_en;
      endcase
   endfunction

   // Count falling edges until the selected pin reaches target; strobes injected as noise.
   task automatic count_until(input int sel, input logic target, input bit noise, output int n);
      n = 0;
      do begin
         if (noise) begin
            pd_cmd   = ($urandom_range(0, 7) == 0);
            live_set = ($urandom_range(0, 7) == 0);
         end
         @(negedge clk);
         n++;
      end while (pick(sel) !== target && n < 3000);
      pd_cmd   = 1'b0;
      live_set = 1'b0;
   endtask

   task automatic make_live();
      live_set = 1'b1;
      @(negedge clk);
      live_set = 1'b0;
      chk_vec("R2 live after strobe", pins, exp_pins(1));
      chk_int("R12 amber off when live", int'(led_amber), 0);
   endtask

   task automatic run_seq(input int gdel, input bit noise, input bit early);
      int n;
      make_live();
      repeat ($urandom_range(0, 4)) @(negedge clk);
      hold_gnt = early;
      pd_cmd   = 1'b1;
      @(negedge clk);
      pd_cmd = 1'b0;
      chk_vec("R3 hold request", pins, exp_pins(2));
      if (early) begin
         @(negedge clk);
         hold_gnt = 1'b0;
         chk_vec("R4 early grant isolates bus", pins, exp_pins(3));
      end else begin
         for (int i = 0; i < gdel; i++) begin
            if (noise) begin
               pd_cmd   = ($urandom_range(0, 3) == 0);
               live_set = ($urandom_range(0, 3) == 0);
            end
            @(negedge clk);
            chk_vec("R3 bus held until grant", pins, exp_pins(2));
         end
         pd_cmd   = 1'b0;
         live_set = 1'b0;
         hold_gnt = 1'b1;
         @(negedge clk);
         hold_gnt = 1'b0;
         chk_vec("R4 bus isolated after grant", pins, exp_pins(3));
      end
      count_until(0, 1'b0, noise, n);
      chk_int("R5 bus-to-reset gap", n, GB);
      chk_vec("R8 R9 reset-on pins", pins, exp_pins(4));
      count_until(1, 1'b1, noise, n);
      chk_int("R6 reset-to-clock gap", n, GR);
      chk_vec("R8 R9 clock-off pins", pins, exp_pins(5));
      count_until(2, 1'b0, noise, n);
      chk_int("R7 clock-to-power gap", n, GC);
      chk_vec("R7 R12 off pins", pins, exp_pins(0));
      chk_int("R7 done pulse", int'(done), 1);
      @(negedge clk);
      chk_int("R7 done one cycle", int'(done), 0);
      pd_cmd = 1'b1;
      @(negedge clk);
      pd_cmd = 1'b0;
      repeat (2) @(negedge clk);
      chk_vec("R9 command ignored while off", pins, exp_pins(0));
      chk_int("R9 no done while off", int'(done), 0);
   endtask

   task automatic reset_mid(input int after);
      make_live();
      hold_gnt = 1'b1;
      pd_cmd   = 1'b1;
      @(negedge clk);
      pd_cmd = 1'b0;
      repeat (after) @(negedge clk);
      hold_gnt = 1'b0;
      #3 rst_n = 1'b0;
      #2;
      chk_vec("R10 async safe state", pins, exp_pins(0));
      chk_int("R10 done low in reset", int'(done), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_vec("R10 safe after release", pins, exp_pins(0));
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk_vec("R1 pins in reset", pins, exp_pins(0));
      chk_int("R1 done in reset", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_vec("R1 pins after release", pins, exp_pins(0));
      hold_gnt = 1'b1;
      pd_cmd   = 1'b1;
      @(negedge clk);
      pd_cmd   = 1'b0;
      hold_gnt = 1'b0;
      @(negedge clk);
      chk_vec("R9 command from off ignored", pins, exp_pins(0));

      run_seq(0, 1'b0, 1'b0);
      run_seq(0, 1'b0, 1'b1);
      run_seq(15, 1'b1, 1'b0);
      reset_mid(1);
      reset_mid(200);
      reset_mid(500);

      for (int k = 0; k < 22; k++) begin
         run_seq($urandom_range(0, 12), 1'($urandom_range(0, 1)), $urandom_range(0, 3) == 0);
         if ($urandom_range(0, 4) == 0) reset_mid($urandom_range(1, 640));
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule